// File: doc/BRIEF.md
# Multiplexed General-Purpose I/O Port

This block is an eight-pin general-purpose I/O port that sits on a simple byte-wide register bus inside a microcontroller. Software sets a direction bit for each pin and writes an output latch. A read of the data address returns the synchronized pin level, not the latch. Pull-up resistors are enabled per nibble: one control bit covers four adjacent pins. Each pin can also be handed to on-chip peripherals. A first-level select bit chooses the latch or a peripheral as the driven value. A second-level field per pin chooses which of four peripheral outputs sharing that pin is used.

When the chip runs with an external bus, a mode input reserves a fixed set of pins for bus control. While it is high, software writes to the direction and latch bits of those pins have no effect, and data reads of those pins return zero. The top pin is input-only because it is shared with the non-maskable interrupt line. It has no direction bit, it is never pulled up and it never drives. Its data bit reads the level of that line.

Register reads are served by a two-state bus machine. BUS_IDLE moves to BUS_RESP on a read strobe. BUS_RESP stays in BUS_RESP on another read strobe and returns to BUS_IDLE otherwise. `rvalid` is high exactly while the machine is in BUS_RESP.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset, every direction, latch, pull-up, select-A and select-B bit is 0, so `pin_oe`, `pin_pu` and `pin_out` are all 0 and `rvalid` is 0.
- R2: A write to byte address 1 sets the direction bits, where 1 means output; `pin_oe[i]` equals direction bit i. Pin 7 has no direction bit: it reads back as 0 and `pin_oe[7]` is always 0.
- R3: A write to byte address 0 loads the output latch. With select-A bit i equal to 0, `pin_out[i]` is latch bit i.
- R4: A read of address 0 returns the pin levels after a two-flop synchronizer. A level driven before clock edge k is returned by a read strobe sampled at edge k+2 or later.
- R5: Address 2 bits [1:0] enable pull-ups for pins 0-3 (bit 0) and pins 4-7 (bit 1). `pin_pu[i]` is high only while its group bit is 1 and pin i is an input. Pin 7 is never pulled up. Bits [7:2] read as 0.
- R6: With select-A bit i (address 3, bit i) equal to 1, `pin_out[i]` is the peripheral output chosen by the second-level field of pin i.
- R7: The second-level field of pin i is 2 bits wide. Pins 0-3 use address 4 and pins 4-7 use address 5, with pin i at bits [2(i mod 4)+1 : 2(i mod 4)]. A field value s selects `periph_out[i*4+s]`.
- R8: While `bus_mode` is 1, writes leave the direction and latch bits of pins 0-3 unchanged, and data reads return 0 on bits 0-3. Bits 4-7 behave normally.
- R9: Bit 7 of a data read is the synchronized level of the shared interrupt pin `pin_in[7]`, whatever has been written to the direction or latch bit of pin 7.
- R10: `rdata` and `rvalid` appear in the cycle after a read strobe. `rvalid` is 1 exactly in the cycles that follow a sampled `rd_en`, so back-to-back reads hold it high.
- R11: Addresses 6 and 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| addr | input | 3 | Register byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| bus_mode | input | 1 | Reserves pins 0-3 for external bus control |
| pin_in | input | 8 | Pad input levels; bit 7 is the interrupt line |
| periph_out | input | 32 | Peripheral outputs, four per pin, pin i at [i*4+3:i*4] |
| pin_out | output | 8 | Value driven to each pad |
| pin_oe | output | 8 | Pad output enable |
| pin_pu | output | 8 | Pad pull-up enable |

## Verification
The hardest case to reach from the ports combines several timings. A reserved-pin write and a data read must land while `bus_mode` is high. The read must also fall inside the synchronizer window of a pin change. That way the bench shows that masking applies to both the old and the new level. The stimulus first switches the pins with the mode low, then raises the mode, writes the locked registers, and reads back in the following cycles. A long random phase then toggles the mode, the addresses and the pin levels together. A cycle-by-cycle model follows the synchronizer delay with a queue of past pin levels.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    localparam int ADDR_DATA = 0;
    localparam int ADDR_DIR  = 1;
    localparam int ADDR_PULL = 2;
    localparam int ADDR_FSA  = 3;
    localparam int ADDR_FSB0 = 4;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int SELW        = 2,
    parameter int NGRP        = 2,
    parameter int IN_ONLY_PIN = 7,
    parameter logic [NPINS-1:0] BUS_PIN_MASK = 8'h0F,
    parameter int AW          = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [AW-1:0]         addr,
    input  logic [NPINS-1:0]      wdata,
    input  logic                  bus_mode,
    input  logic [NPINS-1:0]      pin_sync,
    output logic [NPINS-1:0]      rdata,
    output logic                  rvalid,
    output logic [NPINS-1:0]      dir_q,
    output logic [NPINS-1:0]      latch_q,
    output logic [NGRP-1:0]       pull_q,
    output logic [NPINS-1:0]      fsa_q,
    output logic [NPINS*SELW-1:0] fsb_q
);

    localparam logic [NPINS-1:0] INONLY_MASK = (NPINS)'(1) << IN_ONLY_PIN;

    bus_state_e       state_q;
    bus_state_e       state_d;
    logic [NPINS-1:0] lock;
    logic [NPINS-1:0] lat_wmask;
    logic [NPINS-1:0] dir_wmask;
    logic [NPINS-1:0] rd_mux;
    logic [NPINS-1:0] rdata_q;

    assign lock      = bus_mode ? BUS_PIN_MASK : '0;
    assign lat_wmask = ~lock;
    assign dir_wmask = ~lock & ~INONLY_MASK;

    // register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '0;
            latch_q <= '0;
            pull_q  <= '0;
            fsa_q   <= '0;
            fsb_q   <= '0;
        end else if (wr_en) begin
            if (addr == AW'(ADDR_DATA))
                latch_q <= (latch_q & ~lat_wmask) | (wdata & lat_wmask);
            if (addr == AW'(ADDR_DIR))
                dir_q <= (dir_q & ~dir_wmask) | (wdata & dir_wmask);
            if (addr == AW'(ADDR_PULL))
                pull_q <= wdata[NGRP-1:0];
            if (addr == AW'(ADDR_FSA))
                fsa_q <= wdata;
            for (int k = 0; k < SELW; k++) begin
                if (addr == AW'(ADDR_FSB0 + k))
                    fsb_q[k*NPINS +: NPINS] <= wdata;
            end
        end
    end

    // read selection
    always_comb begin
        rd_mux = '0;
        if (addr == AW'(ADDR_DATA))
            rd_mux = pin_sync & ~lock;
        if (addr == AW'(ADDR_DIR))
            rd_mux = dir_q;
        if (addr == AW'(ADDR_PULL))
            rd_mux = (NPINS)'(pull_q);
        if (addr == AW'(ADDR_FSA))
            rd_mux = fsa_q;
        for (int k = 0; k < SELW; k++) begin
            if (addr == AW'(ADDR_FSB0 + k))
                rd_mux = fsb_q[k*NPINS +: NPINS];
        end
    end

    // bus state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_en)
                rdata_q <= rd_mux;
        end
    end

    // bus next state
    always_comb begin
        unique case (state_q)
            BUS_IDLE: state_d = rd_en ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = rd_en ? BUS_RESP : BUS_IDLE;
        endcase
    end

    // bus outputs
    always_comb begin
        rvalid = (state_q == BUS_RESP);
        rdata  = rdata_q;
    end

endmodule

// File: rtl/gpio_outmux.sv
module gpio_outmux #(
    parameter int NPINS       = 8,
    parameter int NSEL        = 4,
    parameter int SELW        = 2,
    parameter int GROUP       = 4,
    parameter int NGRP        = 2,
    parameter int IN_ONLY_PIN = 7
) (
    input  logic [NPINS-1:0]      dir_q,
    input  logic [NPINS-1:0]      latch_q,
    input  logic [NGRP-1:0]       pull_q,
    input  logic [NPINS-1:0]      fsa_q,
    input  logic [NPINS*SELW-1:0] fsb_q,
    input  logic [NPINS*NSEL-1:0] periph_out,
    output logic [NPINS-1:0]      pin_out,
    output logic [NPINS-1:0]      pin_oe,
    output logic [NPINS-1:0]      pin_pu
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic [SELW-1:0] sel;
        logic [NSEL-1:0] cand;
        logic            pval;

        assign sel  = fsb_q[i*SELW +: SELW];
        assign cand = periph_out[i*NSEL +: NSEL];
        assign pval = (int'(sel) < NSEL) ? cand[sel] : 1'b0;

        assign pin_out[i] = fsa_q[i] ? pval : latch_q[i];

        if (i == IN_ONLY_PIN) begin : g_inonly
            assign pin_oe[i] = 1'b0 & dir_q[i];
            assign pin_pu[i] = 1'b0 & pull_q[i/GROUP];
        end else begin : g_io
            assign pin_oe[i] = dir_q[i];
            assign pin_pu[i] = pull_q[i/GROUP] & ~dir_q[i];
        end
    end

endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port #(
    parameter int NPINS       = 8,
    parameter int NSEL        = 4,
    parameter int GROUP       = 4,
    parameter int IN_ONLY_PIN = 7,
    parameter logic [NPINS-1:0] BUS_PIN_MASK = 8'h0F,
    parameter int AW          = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [AW-1:0]         addr,
    input  logic [NPINS-1:0]      wdata,
    output logic [NPINS-1:0]      rdata,
    output logic                  rvalid,
    input  logic                  bus_mode,
    input  logic [NPINS-1:0]      pin_in,
    input  logic [NPINS*NSEL-1:0] periph_out,
    output logic [NPINS-1:0]      pin_out,
    output logic [NPINS-1:0]      pin_oe,
    output logic [NPINS-1:0]      pin_pu
);

    localparam int SELW = $clog2(NSEL);
    localparam int NGRP = NPINS / GROUP;

    logic [NPINS-1:0]      pin_sync;
    logic [NPINS-1:0]      dir_q;
    logic [NPINS-1:0]      latch_q;
    logic [NGRP-1:0]       pull_q;
    logic [NPINS-1:0]      fsa_q;
    logic [NPINS*SELW-1:0] fsb_q;

    gpio_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    gpio_regfile #(
        .NPINS        (NPINS),
        .SELW         (SELW),
        .NGRP         (NGRP),
        .IN_ONLY_PIN  (IN_ONLY_PIN),
        .BUS_PIN_MASK (BUS_PIN_MASK),
        .AW           (AW)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .bus_mode (bus_mode),
        .pin_sync (pin_sync),
        .rdata    (rdata),
        .rvalid   (rvalid),
        .dir_q    (dir_q),
        .latch_q  (latch_q),
        .pull_q   (pull_q),
        .fsa_q    (fsa_q),
        .fsb_q    (fsb_q)
    );

    gpio_outmux #(
        .NPINS       (NPINS),
        .NSEL        (NSEL),
        .SELW        (SELW),
        .GROUP       (GROUP),
        .NGRP        (NGRP),
        .IN_ONLY_PIN (IN_ONLY_PIN)
    ) u_mux (
        .dir_q      (dir_q),
        .latch_q    (latch_q),
        .pull_q     (pull_q),
        .fsa_q      (fsa_q),
        .fsb_q      (fsb_q),
        .periph_out (periph_out),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe),
        .pin_pu     (pin_pu)
    );

endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk #(
    parameter int NPINS       = 8,
    parameter int IN_ONLY_PIN = 7,
    parameter logic [NPINS-1:0] BUS_PIN_MASK = 8'h0F,
    parameter int AW          = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic [AW-1:0]    addr,
    input logic             bus_mode,
    input logic [NPINS-1:0] rdata,
    input logic             rvalid,
    input logic [NPINS-1:0] pin_oe,
    input logic [NPINS-1:0] pin_pu,
    input logic [NPINS-1:0] dir_q,
    input logic [NPINS-1:0] latch_q
);

    assert_inonly_no_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe[IN_ONLY_PIN]);

    assert_inonly_no_pull_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_pu[IN_ONLY_PIN]);

    assert_pull_only_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu & pin_oe) == '0);

    assert_rvalid_follows_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);

    assert_rvalid_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid);

    assert_dir_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_mode && wr_en && addr == AW'(1))
        |=> ((dir_q & BUS_PIN_MASK) == ($past(dir_q) & BUS_PIN_MASK)));

    assert_latch_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_mode && wr_en && addr == AW'(0))
        |=> ((latch_q & BUS_PIN_MASK) == ($past(latch_q) & BUS_PIN_MASK)));

    assert_read_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_mode && rd_en && addr == AW'(0)) |=> ((rdata & BUS_PIN_MASK) == '0));

endmodule

bind gpio_mux_port gpio_mux_port_chk #(
    .NPINS        (NPINS),
    .IN_ONLY_PIN  (IN_ONLY_PIN),
    .BUS_PIN_MASK (BUS_PIN_MASK),
    .AW           (AW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .bus_mode (bus_mode),
    .rdata    (rdata),
    .rvalid   (rvalid),
    .pin_oe   (pin_oe),
    .pin_pu   (pin_pu),
    .dir_q    (dir_q),
    .latch_q  (latch_q)
);

// File: tb/gpio_mux_port_tb.sv
`timescale 1ns/1ps
module gpio_mux_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rvalid;
    logic        bus_mode = 1'b0;
    logic [7:0]  pin_in = '0;
    logic [31:0] periph_out = '0;
    logic [7:0]  pin_out;
    logic [7:0]  pin_oe;
    logic [7:0]  pin_pu;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_mux_port dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .rvalid     (rvalid),
        .bus_mode   (bus_mode),
        .pin_in     (pin_in),
        .periph_out (periph_out),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe),
        .pin_pu     (pin_pu)
    );

    // behavioural reference state
    int        m_dir[8];
    int        m_lat[8];
    int        m_pull[2];
    int        m_fsa[8];
    int        m_fsb[8];
    logic [7:0] hist[$];
    int        m_rdata = 0;
    int        m_rvalid = 0;

    function automatic void model_reset();
        for (int i = 0; i < 8; i++) begin
            m_dir[i] = 0; m_lat[i] = 0; m_fsa[i] = 0; m_fsb[i] = 0;
        end
        m_pull[0] = 0; m_pull[1] = 0;
        hist.delete();
        hist.push_back(8'h00);
        hist.push_back(8'h00);
        m_rdata = 0;
        m_rvalid = 0;
    endfunction

    function automatic int model_read(int a, logic [7:0] seen, bit bm);
        int v = 0;
        case (a)
            0: for (int i = 0; i < 8; i++)
                   if (!(bm && i < 4) && seen[i]) v |= (1 << i);
            1: for (int i = 0; i < 8; i++) v |= (m_dir[i] << i);
            2: v = m_pull[0] | (m_pull[1] << 1);
            3: for (int i = 0; i < 8; i++) v |= (m_fsa[i] << i);
            4: for (int i = 0; i < 4; i++) v |= (m_fsb[i] << (2*i));
            5: for (int i = 0; i < 4; i++) v |= (m_fsb[i+4] << (2*i));
            default: v = 0;
        endcase
        return v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            int rv;
            logic [7:0] seen;
            seen = hist[hist.size()-2];
            rv = model_read(int'(addr), seen, bus_mode);
            if (wr_en) begin
                case (int'(addr))
                    0: for (int i = 0; i < 8; i++)
                           if (!(bus_mode && i < 4)) m_lat[i] = wdata[i];
                    1: for (int i = 0; i < 7; i++)
                           if (!(bus_mode && i < 4)) m_dir[i] = wdata[i];
                    2: begin m_pull[0] = wdata[0]; m_pull[1] = wdata[1]; end
                    3: for (int i = 0; i < 8; i++) m_fsa[i] = wdata[i];
                    4: for (int i = 0; i < 4; i++) m_fsb[i] = (wdata >> (2*i)) & 3;
                    5: for (int i = 0; i < 4; i++) m_fsb[i+4] = (wdata >> (2*i)) & 3;
                    default: ;
                endcase
            end
            if (rd_en) begin
                m_rdata = rv;
                m_rvalid = 1;
            end else begin
                m_rvalid = 0;
            end
            hist.push_back(pin_in);
            if (hist.size() > 4) void'(hist.pop_front());
        end
    end

    task automatic check(string req, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [7:0] e_out, e_oe, e_pu;
        for (int i = 0; i < 8; i++) begin
            e_out[i] = m_fsa[i] ? periph_out[i*4 + m_fsb[i]] : 1'(m_lat[i]);
            e_oe[i]  = (i != 7) && m_dir[i] != 0;
            e_pu[i]  = (i != 7) && m_pull[i/4] != 0 && m_dir[i] == 0;
        end
        check("R3/R6/R7", "pin_out", int'(pin_out), int'(e_out));
        check("R2", "pin_oe", int'(pin_oe), int'(e_oe));
        check("R5", "pin_pu", int'(pin_pu), int'(e_pu));
        check("R10", "rvalid", int'(rvalid), m_rvalid);
        if (m_rvalid != 0) check("R4", "rdata", int'(rdata), m_rdata);
    endtask

    task automatic tick();
        @(negedge clk);
        if (rst_n) compare_all();
    endtask

    task automatic do_wr(int a, int d);
        wr_en = 1'b1; addr = 3'(a); wdata = 8'(d);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic do_rd(int a);
        rd_en = 1'b1; addr = 3'(a);
        tick();
        rd_en = 1'b0;
        tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        miscompares++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R1: everything cleared after reset
        check("R1", "pin_oe reset", int'(pin_oe), 0);
        check("R1", "pin_pu reset", int'(pin_pu), 0);
        check("R1", "pin_out reset", int'(pin_out), 0);
        check("R1", "rvalid reset", int'(rvalid), 0);
        for (int a = 0; a < 8; a++) do_rd(a);

        // R2 / R3: direction and latch; pin 7 direction bit stays 0
        do_wr(1, 8'hFF);
        check("R2", "pin7 oe", int'(pin_oe[7]), 0);
        do_rd(1);
        do_wr(0, 8'h5A);
        do_wr(1, 8'h0F);

        // R4 / R9: pin change seen two clocks later, pin 7 is the interrupt line
        pin_in = 8'hA5;
        rd_en = 1'b1; addr = 3'd0;
        repeat (4) tick();
        rd_en = 1'b0;
        tick();
        pin_in = 8'h80;
        do_wr(0, 8'h7F);
        do_rd(0);
        do_rd(0);

        // R5: nibble pull-ups, only on inputs
        do_wr(2, 8'hFF);
        do_rd(2);
        do_wr(1, 8'hF0);
        do_wr(2, 8'h01);
        do_wr(1, 8'h00);

        // R6 / R7: peripheral selection
        periph_out = 32'h9C3A_6E15;
        do_wr(3, 8'hFF);
        do_wr(4, 8'hE4);
        do_wr(5, 8'h1B);
        do_rd(4);
        do_rd(5);
        for (int k = 0; k < 8; k++) begin
            periph_out = {periph_out[27:0], periph_out[31:28]} ^ 32'(k * 32'h1111_0101);
            tick();
        end
        do_wr(3, 8'h33);

        // R8: bus mode locks pins 0-3
        do_wr(1, 8'h0F);
        do_wr(0, 8'h0F);
        pin_in = 8'h3C;
        bus_mode = 1'b1;
        do_wr(1, 8'hF0);
        do_wr(0, 8'hF0);
        check("R8", "dir locked low nibble", int'(pin_oe[3:0]), 4'hF);
        do_rd(0);
        do_rd(1);
        bus_mode = 1'b0;
        do_rd(0);

        // R11: unmapped addresses
        do_wr(6, 8'hFF);
        do_wr(7, 8'hFF);
        do_rd(6);
        do_rd(7);
        for (int a = 0; a < 6; a++) do_rd(a);

        // random mixed traffic
        for (int n = 0; n < 3000; n++) begin
            wr_en = 1'($urandom_range(0, 2) == 0);
            rd_en = 1'($urandom_range(0, 1));
            addr = 3'($urandom_range(0, 7));
            wdata = 8'($urandom);
            if ($urandom_range(0, 3) == 0) pin_in = 8'($urandom);
            if ($urandom_range(0, 3) == 0) periph_out = $urandom;
            if ($urandom_range(0, 15) == 0) bus_mode = ~bus_mode;
            tick();
        end
        wr_en = 1'b0; rd_en = 1'b0;
        tick();
        tick();
        finish_run();
    end

endmodule